// File: doc/BRIEF.md
# Alternating-Slot Overflow Flag with Shared Hold Timer

This block turns per-channel overrange pulses from a stereo converter into one active-low, open-drain overflow line. The line is time-shared. During one half of each word-clock (LRCK) frame it carries the left channel's overflow status, and during the other half it carries the right channel's status. A receiver can therefore recover both bits by latching the line on the two LRCK edges. Which half carries which channel, and how many bit-clock (SCLK) edges the line waits after an LRCK transition before it changes, both depend on the serial format: I2S or left-justified.

An overrange pulse on a channel sets that channel's status at once. Any overrange on either channel reloads one shared hold timer, and the timer counts LRCK frames. When the timer runs out with no new event, both statuses clear together. The default length is 32640 frames, which comes to roughly 0.68 s at 48 kHz-family rates and 0.74 s at 44.1 kHz-family rates. LRCK and SCLK are sampled in the block's own clock domain. The output is a pull-down enable: 1 means drive the pad low, and 0 means release it to the external pull-up.

Top module: `ovf_indicator`

## Requirements
- R1: While `rst_n` is low, `ovfl_pull` is 0 and both channel statuses and the hold timer are cleared. After reset is released, no status is reported until a new overrange pulse arrives.
- R2: A one-cycle pulse on `ovr_left` (or `ovr_right`) sets that channel's status from the next clock. The status is then driven as `ovfl_pull` = 1 during that channel's slot.
- R3: With no overrange pulse since reset, `ovfl_pull` stays 0 in both slots and the hold timer stays at zero.
- R4: With `fmt_i2s` = 0 (left-justified), the half frame with `lrck` = 1 carries the left status and the half frame with `lrck` = 0 carries the right status.
- R5: With `fmt_i2s` = 1 (I2S), the half frame with `lrck` = 0 carries the left status and the half frame with `lrck` = 1 carries the right status.
- R6: In left-justified format, `ovfl_pull` takes its new slot value in the clock after the first SCLK rising edge that follows an LRCK transition.
- R7: In I2S format, `ovfl_pull` takes its new slot value in the clock after the second SCLK rising edge that follows an LRCK transition.
- R8: `ovfl_pull` changes only in the clock after an SCLK rising edge. It is never updated mid-slot by a new overrange, so it stays stable for the rest of the half frame, which is well over 16 SCLK periods before the latching LRCK edge.
- R9: Both statuses clear together on the HOLD_FRAMES-th LRCK rising edge after the most recent overrange pulse.
- R10: An overrange pulse on either channel reloads the shared timer to HOLD_FRAMES. This also extends a status the other channel had already set. When an overrange pulse and an LRCK rising edge arrive in the same clock, the reload wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; LRCK and SCLK are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Word clock, sampled level |
| sclk | input | 1 | Bit clock, sampled level |
| fmt_i2s | input | 1 | 1 selects I2S slot timing, 0 selects left-justified |
| ovr_left | input | 1 | One-cycle overrange pulse for the left channel |
| ovr_right | input | 1 | One-cycle overrange pulse for the right channel |
| ovfl_pull | output | 1 | Open-drain enable: 1 pulls the overflow line low |

## Verification
The bench builds the block with HOLD_FRAMES = 3 instead of 32640. This brings the expiry frame, a restart that lands one frame before the expiry, and the simultaneous clearing of both statuses within a few frames of stimulus. The bench uses an SCLK of 8 block clocks and a 64-SCLK frame. With these values the one-edge and two-edge update lags can be observed on exact clock cycles on either side of the update point.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    // State of the slot driver: SCLK edges still to wait, and the pad enable.
    typedef struct packed {
        logic [1:0] lag;
        logic       pull;
    } slot_st_t;

    // Number of SCLK rising edges between an LRCK transition and the slot update.
    function automatic logic [1:0] slot_lag(input logic i2s);
        return i2s ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/ovf_sampler.sv
module ovf_sampler #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] prev
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign prev = prev_q;
endmodule

// File: rtl/ovf_hold_timer.sv
module ovf_hold_timer #(
    parameter int HOLD_FRAMES = 32640,
    localparam int CW = $clog2(HOLD_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ovr_l,
    input  logic          ovr_r,
    input  logic          frame_tick,
    output logic          flag_l,
    output logic          flag_r,
    output logic [CW-1:0] remain
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fl;
        logic          fr;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ovr_l || ovr_r) begin
            // any event restarts the shared window; reload beats a frame tick
            st_d.cnt = CW'(HOLD_FRAMES);
            st_d.fl  = st_q.fl | ovr_l;
            st_d.fr  = st_q.fr | ovr_r;
        end else if (frame_tick && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.fl = 1'b0;
                st_d.fr = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_l = st_q.fl;
    assign flag_r = st_q.fr;
    assign remain = st_q.cnt;
endmodule

// File: rtl/ovf_slot_mux.sv
module ovf_slot_mux
    import ovf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lrck_lvl,
    input  logic lrck_chg,
    input  logic sclk_rise,
    input  logic fmt_i2s,
    input  logic flag_l,
    input  logic flag_r,
    output logic pull
);
    slot_st_t st_d, st_q;
    logic     show_left;

    always_comb begin
        show_left = fmt_i2s ? ~lrck_lvl : lrck_lvl;
        st_d      = st_q;
        if (lrck_chg) begin
            st_d.lag = slot_lag(fmt_i2s);
        end else if (sclk_rise && st_q.lag != 2'd0) begin
            st_d.lag = st_q.lag - 2'd1;
            if (st_q.lag == 2'd1) begin
                st_d.pull = show_left ? flag_l : flag_r;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pull = st_q.pull;
endmodule

// File: rtl/ovf_indicator.sv
module ovf_indicator #(
    parameter int HOLD_FRAMES = 32640
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lrck,
    input  logic sclk,
    input  logic fmt_i2s,
    input  logic ovr_left,
    input  logic ovr_right,
    output logic ovfl_pull
);
    localparam int CW    = $clog2(HOLD_FRAMES + 1);
    localparam int NSIG  = 2;
    localparam int I_LR  = 0;
    localparam int I_SCK = 1;

    logic [NSIG-1:0] clk_lvls;
    logic [NSIG-1:0] clk_prev;
    logic            sclk_rise;
    logic            lrck_rise;
    logic            lrck_chg;
    logic            flag_l;
    logic            flag_r;
    logic [CW-1:0]   hold_cnt;

    assign clk_lvls = {sclk, lrck};

    ovf_sampler #(.N(NSIG)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (clk_lvls),
        .prev  (clk_prev)
    );

    assign sclk_rise = clk_lvls[I_SCK] & ~clk_prev[I_SCK];
    assign lrck_rise = clk_lvls[I_LR]  & ~clk_prev[I_LR];
    assign lrck_chg  = clk_lvls[I_LR]  ^  clk_prev[I_LR];

    ovf_hold_timer #(.HOLD_FRAMES(HOLD_FRAMES)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovr_l      (ovr_left),
        .ovr_r      (ovr_right),
        .frame_tick (lrck_rise),
        .flag_l     (flag_l),
        .flag_r     (flag_r),
        .remain     (hold_cnt)
    );

    ovf_slot_mux u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .lrck_lvl  (lrck),
        .lrck_chg  (lrck_chg),
        .sclk_rise (sclk_rise),
        .fmt_i2s   (fmt_i2s),
        .flag_l    (flag_l),
        .flag_r    (flag_r),
        .pull      (ovfl_pull)
    );
endmodule

// File: rtl/ovf_indicator_chk.sv
module ovf_indicator_chk #(
    parameter int HOLD_FRAMES = 32640,
    localparam int CW = $clog2(HOLD_FRAMES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ovr_left,
    input logic          ovr_right,
    input logic          sclk_rise,
    input logic          flag_l,
    input logic          flag_r,
    input logic [CW-1:0] hold_cnt,
    input logic          ovfl_pull
);
    p_left_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_left |=> flag_l);

    p_right_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_right |=> flag_r);

    p_idle_timer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_l && !flag_r) |-> (hold_cnt == '0));

    p_pull_on_sclk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovfl_pull != $past(ovfl_pull)) |-> $past(sclk_rise));

    p_left_clears_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_l) |-> !flag_r);

    p_right_clears_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_r) |-> !flag_l);

    p_event_reloads_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_left || ovr_right) |=> (hold_cnt == CW'(HOLD_FRAMES)));
endmodule

bind ovf_indicator ovf_indicator_chk #(.HOLD_FRAMES(HOLD_FRAMES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovr_left  (ovr_left),
    .ovr_right (ovr_right),
    .sclk_rise (sclk_rise),
    .flag_l    (flag_l),
    .flag_r    (flag_r),
    .hold_cnt  (hold_cnt),
    .ovfl_pull (ovfl_pull)
);

// File: tb/ovf_indicator_bench.sv
module ovf_indicator_bench;
    localparam int HOLD     = 3;
    localparam int FRAME    = 512;   // 64 SCLK x 8 clocks
    localparam int HALF     = 256;
    // {fmt_i2s, ovr_l, ovr_r, expect high half, expect low half}
    localparam logic [4:0] VEC [8] = '{
        5'b0_10_1_0, 5'b0_01_0_1, 5'b0_11_1_1, 5'b0_00_0_0,
        5'b1_10_0_1, 5'b1_01_1_0, 5'b1_11_1_1, 5'b1_00_0_0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lrck = 1'b0;
    logic sclk = 1'b0;
    logic fmt_i2s = 1'b0;
    logic ovr_left = 1'b0;
    logic ovr_right = 1'b0;
    logic ovfl_pull;

    int n_checks = 0;
    int n_fail = 0;
    int drv_ph = 0;
    int done_ph = FRAME - 1;
    logic req_l = 1'b0;
    logic req_r = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ovf_indicator #(.HOLD_FRAMES(HOLD)) u_ovf_indicator (
        .clk       (clk),
        .rst_n     (rst_n),
        .lrck      (lrck),
        .sclk      (sclk),
        .fmt_i2s   (fmt_i2s),
        .ovr_left  (ovr_left),
        .ovr_right (ovr_right),
        .ovfl_pull (ovfl_pull)
    );

    task automatic tick();
        @(negedge clk);
        done_ph   = drv_ph;
        drv_ph    = (drv_ph + 1) % FRAME;
        sclk      = ((drv_ph % 8) >= 4);
        lrck      = (drv_ph >= HALF);
        ovr_left  = req_l;
        ovr_right = req_r;
        req_l     = 1'b0;
        req_r     = 1'b0;
    endtask

    task automatic goto(input int p);
        do tick(); while (done_ph != p);
    endtask

    task automatic inject(input logic l, input logic r, input int p);
        goto(p - 2);
        req_l = l;
        req_r = r;
        tick();
    endtask

    task automatic do_reset(input logic i2s);
        rst_n = 1'b0;
        fmt_i2s = i2s;
        repeat (4) tick();
        rst_n = 1'b1;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: ovfl_pull=%0b expected %0b (phase %0d)", tag, act, exp, done_ph);
        end
    endtask

    initial begin
        // R1: reset state
        do_reset(1'b0);
        rst_n = 1'b0;
        tick();
        chk(ovfl_pull, 1'b0, "R1 reset");
        rst_n = 1'b1;

        // table walk: R2/R3 with R4 (left-justified) or R5 (I2S) slot mapping
        foreach (VEC[i]) begin
            do_reset(VEC[i][4]);
            inject(VEC[i][3], VEC[i][2], 100);
            goto(384);
            chk(ovfl_pull, VEC[i][1], VEC[i][4] ? "R5 high half (R2/R3)" : "R4 high half (R2/R3)");
            goto(128);
            chk(ovfl_pull, VEC[i][0], VEC[i][4] ? "R5 low half (R2/R3)" : "R4 low half (R2/R3)");
        end

        // R6/R8: left-justified update on first SCLK rise after LRCK edge
        do_reset(1'b0);
        inject(1'b1, 1'b0, 100);
        goto(259);
        chk(ovfl_pull, 1'b0, "R6 R8 before first SCLK rise");
        goto(260);
        chk(ovfl_pull, 1'b1, "R6 at first SCLK rise");

        // R7: I2S update on second SCLK rise after LRCK edge
        do_reset(1'b1);
        inject(1'b0, 1'b1, 100);
        goto(267);
        chk(ovfl_pull, 1'b0, "R7 before second SCLK rise");
        goto(268);
        chk(ovfl_pull, 1'b1, "R7 at second SCLK rise");

        // R9: both clear on the HOLD-th LRCK rise
        do_reset(1'b0);
        inject(1'b1, 1'b1, 100);
        goto(384); goto(384);
        chk(ovfl_pull, 1'b1, "R9 left held one frame later");
        goto(128);
        chk(ovfl_pull, 1'b1, "R9 right held before expiry edge");
        goto(384);
        chk(ovfl_pull, 1'b0, "R9 left cleared after expiry edge");
        goto(128);
        chk(ovfl_pull, 1'b0, "R9 right cleared after expiry edge");

        // R10: right event restarts the window for the left status
        do_reset(1'b0);
        inject(1'b1, 1'b0, 100);
        inject(1'b0, 1'b1, 100);
        goto(384); goto(384);
        chk(ovfl_pull, 1'b1, "R10 left extended by right event");
        goto(384);
        chk(ovfl_pull, 1'b0, "R10 left cleared after restarted window");

        // R1: reset during a hold drops the line and clears the timer
        do_reset(1'b0);
        inject(1'b1, 1'b0, 100);
        goto(384);
        rst_n = 1'b0;
        tick();
        chk(ovfl_pull, 1'b0, "R1 line released in reset");
        rst_n = 1'b1;
        goto(384);
        chk(ovfl_pull, 1'b0, "R1 no status after reset");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule